// File: doc/BRIEF.md
# One-Hot Controlled Funnel Shifter

This block is a purely combinational window selector. Two N-bit operands are joined into a 2N-bit word, with `upper_in` as the high half and `lower_in` as the low half. A one-hot column select picks the bit where an N-bit window of that word begins. The window appears on `win_out` in the same cycle, with no clock involved, so any distance from 0 to N-1 takes a single pass.

What goes into the two halves decides the operation. The same word in both halves gives a right rotate. Zeros in the upper half give a logical right shift. An arbitrary pair of words lets a caller pull a bit field that straddles the two operands down to the low end of the output.

Internally the select is an N-by-N grid of gating cells, one cell for each pairing of output bit and control column, fed along diagonals. A classifier checks the control lines. Any pattern other than exactly one asserted line forces the output to zero and raises `sel_err`. N defaults to 8 and must be at least 2.

Top module: `fsh_funnel`

## Requirements
- R1: With exactly one control line `col_sel[k]` high, `win_out[i]` equals bit `i+k` of the word `{upper_in, lower_in}` for every i in 0..N-1. The upper half occupies bits 2N-1..N and the lower half occupies bits N-1..0.
- R2: With `col_sel[0]` as the only line high, `win_out` equals `lower_in` and `upper_in` has no effect.
- R3: With `col_sel[N-1]` as the only line high, `win_out` is `{upper_in[N-2:0], lower_in[N-1]}`, and `upper_in[N-1]` has no effect on the output.
- R4: With `upper_in == lower_in` and only `col_sel[k]` high, `win_out` is `lower_in` rotated right by k.
- R5: With `upper_in` all zeros and only `col_sel[k]` high, `win_out` is `lower_in` logically shifted right by k, with zeros entering at the top.
- R6: With all control lines low, `win_out` is all zeros and `sel_err` is 1.
- R7: With two or more control lines high, `win_out` is all zeros and `sel_err` is 1, whatever the data inputs hold.
- R8: With exactly one control line high, `sel_err` is 0.
- R9: The output follows a change on any input without a clock edge. There is no internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| upper_in | input | N | High half of the 2N-bit source word |
| lower_in | input | N | Low half of the 2N-bit source word |
| col_sel | input | N | One-hot column select; bit k starts the window at word bit k |
| win_out | output | N | Selected N-bit window, or zero when the select is invalid |
| sel_err | output | 1 | High when `col_sel` is not exactly one-hot |

## Verification
The window function is tried with several patterns, each of which separates a different kind of fault:
- Lone set bits and asymmetric words such as `AA/55` expose a cell that sits on the wrong diagonal.
- Identical halves check the wrap-around path of a rotate.
- A zero upper half checks that zeros fill from the top.
- Halves that differ only in their top bit show whether the never-selected bit 2N-1 leaks into the output.

A sweep of all N one-hot codes against a part-select reference covers every column. Empty, paired and all-ones select patterns confirm the zeroing and the error flag. Changing the inputs between two samples with no clock edge in between shows that the path holds no state.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    localparam int unsigned FSH_DEF_N = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ONE  = 2'd1,
        SEL_MANY = 2'd2
    } sel_class_e;

endpackage

// File: rtl/fsh_sel_classify.sv
module fsh_sel_classify
    import fsh_pkg::*;
#(
    parameter int unsigned N = FSH_DEF_N
) (
    input  logic [N-1:0] col_sel,
    output sel_class_e   cls
);

    // seen[j]: some line in 0..j is high; dup[j]: two or more lines in 0..j are high
    logic [N-1:0] seen;
    logic [N-1:0] dup;

    assign seen[0] = col_sel[0];
    assign dup[0]  = 1'b0;

    for (genvar j = 1; j < N; j++) begin : g_chain
        assign seen[j] = seen[j-1] | col_sel[j];
        assign dup[j]  = dup[j-1] | (seen[j-1] & col_sel[j]);
    end

    always_comb begin
        if (dup[N-1])       cls = SEL_MANY;
        else if (seen[N-1]) cls = SEL_ONE;
        else                cls = SEL_NONE;
    end

endmodule

// File: rtl/fsh_cell.sv
module fsh_cell (
    input  logic d,
    input  logic en,
    output logic o
);

    assign o = d & en;

endmodule

// File: rtl/fsh_row.sv
module fsh_row #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] taps,
    input  logic [N-1:0] en,
    output logic         o
);

    // taps[k] is the word bit this row receives from column k
    logic [N-1:0] hit;

    for (genvar k = 0; k < N; k++) begin : g_cell
        fsh_cell u_cell (
            .d  (taps[k]),
            .en (en[k]),
            .o  (hit[k])
        );
    end

    assign o = |hit;

endmodule

// File: rtl/fsh_funnel.sv
module fsh_funnel
    import fsh_pkg::*;
#(
    parameter int unsigned N = FSH_DEF_N
) (
    input  logic [N-1:0] upper_in,
    input  logic [N-1:0] lower_in,
    input  logic [N-1:0] col_sel,
    output logic [N-1:0] win_out,
    output logic         sel_err
);

    localparam int unsigned SPAN = 2 * N - 1;

    // Bit 2N-1 of the full word never lands in any window, so it is left out here
    logic [SPAN-1:0] span_w;
    sel_class_e      cls;
    logic            sel_ok;
    logic [N-1:0]    col_en;

    assign span_w = {upper_in[N-2:0], lower_in};

    fsh_sel_classify #(.N(N)) u_cls (
        .col_sel (col_sel),
        .cls     (cls)
    );

    assign sel_ok  = (cls == SEL_ONE);
    assign sel_err = ~sel_ok;
    // Gating the N column enables is cheaper than gating the N outputs
    assign col_en  = col_sel & {N{sel_ok}};

    for (genvar i = 0; i < N; i++) begin : g_row
        fsh_row #(.N(N)) u_row (
            .taps (span_w[i +: N]),
            .en   (col_en),
            .o    (win_out[i])
        );
    end

endmodule

// File: rtl/fsh_funnel_chk.sv
module fsh_funnel_chk #(
    parameter int unsigned N = 8
) (
    input logic [N-1:0] upper_in,
    input logic [N-1:0] lower_in,
    input logic [N-1:0] col_sel,
    input logic [N-1:0] win_out,
    input logic         sel_err
);

    logic [2*N-1:0] full_w;
    logic [N-1:0]   ref_win;
    logic [N-1:0]   ref_rot;
    logic [N-1:0]   ref_lsr;
    logic           one_hot;

    always_comb begin
        full_w  = {upper_in, lower_in};
        one_hot = $onehot(col_sel);
        ref_win = '0;
        ref_rot = '0;
        ref_lsr = '0;
        for (int k = 0; k < N; k++) begin
            if (col_sel[k]) begin
                ref_win = full_w[k +: N];
                ref_lsr = lower_in >> k;
                ref_rot = (lower_in >> k) | (lower_in << (N - k));
            end
        end
    end

    always_comb begin
        // R1
        if (one_hot) begin
            window_chk: assert (win_out == ref_win);
        end
        // R4
        if (one_hot && upper_in == lower_in) begin
            rotate_chk: assert (win_out == ref_rot);
        end
        // R5
        if (one_hot && upper_in == '0) begin
            lsr_chk: assert (win_out == ref_lsr);
        end
        // R6
        if (col_sel == '0) begin
            empty_sel_chk: assert (win_out == '0 && sel_err);
        end
        // R7
        if (!one_hot && col_sel != '0) begin
            multi_sel_chk: assert (win_out == '0 && sel_err);
        end
        // R8
        if (one_hot) begin
            err_clear_chk: assert (!sel_err);
        end
    end

endmodule

bind fsh_funnel fsh_funnel_chk #(.N(N)) u_chk (
    .upper_in (upper_in),
    .lower_in (lower_in),
    .col_sel  (col_sel),
    .win_out  (win_out),
    .sel_err  (sel_err)
);

// File: tb/tb_fsh_funnel.sv
module tb_fsh_funnel;

    localparam int N = 8;
    localparam int NV = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [N-1:0] upper_in, lower_in, col_sel, win_out;
    logic         sel_err;

    fsh_funnel #(.N(N)) dut (
        .upper_in (upper_in),
        .lower_in (lower_in),
        .col_sel  (col_sel),
        .win_out  (win_out),
        .sel_err  (sel_err)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Vector layout: {upper, lower, select, expected window, expected error}
    localparam logic [32:0] VEC [NV] = '{
        {8'h00, 8'hA5, 8'h01, 8'hA5, 1'b0},   // R2 k=0
        {8'hFF, 8'h00, 8'h80, 8'hFE, 1'b0},   // R3 k=7
        {8'h00, 8'hF0, 8'h10, 8'h0F, 1'b0},   // R5 k=4
        {8'h3C, 8'h3C, 8'h04, 8'h0F, 1'b0},   // R4 k=2
        {8'h12, 8'h34, 8'h00, 8'h00, 1'b1},   // R6
        {8'hFF, 8'hFF, 8'h03, 8'h00, 1'b1},   // R7
        {8'hFF, 8'hFF, 8'hFF, 8'h00, 1'b1},   // R7
        {8'h81, 8'h00, 8'h40, 8'h04, 1'b0},   // R1 k=6
        {8'h01, 8'h80, 8'h02, 8'hC0, 1'b0},   // R1 k=1
        {8'hAA, 8'h55, 8'h08, 8'h4A, 1'b0}    // R1 k=3
    };

    task automatic check(input string req, input logic [N-1:0] got,
                         input logic [N-1:0] exp, input logic gerr, input logic eerr);
        n_chk++;
        if (got !== exp || gerr !== eerr) begin
            n_fail++;
            $display("FAIL %s: win_out=%h sel_err=%b expected win_out=%h sel_err=%b",
                     req, got, gerr, exp, eerr);
        end
    endtask

    task automatic apply(input logic [N-1:0] u, input logic [N-1:0] l, input logic [N-1:0] s);
        @(negedge clk);
        upper_in = u;
        lower_in = l;
        col_sel  = s;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2*N-1:0] w;
        logic [N-1:0]   d;
        logic [31:0]    lfsr;
        upper_in = '0;
        lower_in = '0;
        col_sel  = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // Reset state: all-zero select gives zero output with the error flag (R6)
        check("R6 reset state", win_out, '0, sel_err, 1'b1);

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][32:25], VEC[v][24:17], VEC[v][16:9]);
            check($sformatf("R1 table vector %0d", v), win_out, VEC[v][8:1], sel_err, VEC[v][0]);
        end

        // R1 sweep of every one-hot code against a part-select reference
        lfsr = 32'h1ACE_B00C;
        for (int r = 0; r < 6; r++) begin
            for (int k = 0; k < N; k++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                apply(lfsr[15:8], lfsr[7:0], N'(1) << k);
                w = {lfsr[15:8], lfsr[7:0]};
                check($sformatf("R1 sweep k=%0d", k), win_out, w[k +: N], sel_err, 1'b0);
            end
        end

        // R2 upper half has no effect at k=0
        apply(8'h5A, 8'h3C, 8'h01);
        check("R2 k=0 upper ignored", win_out, 8'h3C, sel_err, 1'b0);
        apply(8'hFF, 8'h3C, 8'h01);
        check("R2 k=0 upper ignored", win_out, 8'h3C, sel_err, 1'b0);

        // R3 top word bit has no effect at k=N-1
        apply(8'h7F, 8'h80, 8'h80);
        check("R3 k=7 bit15 clear", win_out, 8'hFF, sel_err, 1'b0);
        apply(8'hFF, 8'h80, 8'h80);
        check("R3 k=7 bit15 set", win_out, 8'hFF, sel_err, 1'b0);

        // R4 rotate of a lone bit at every distance
        for (int k = 0; k < N; k++) begin
            apply(8'h01, 8'h01, N'(1) << k);
            d = (k == 0) ? 8'h01 : (N'(1) << (N - k));
            check($sformatf("R4 rotate k=%0d", k), win_out, d, sel_err, 1'b0);
        end

        // R5 logical shift of all ones
        for (int k = 0; k < N; k++) begin
            apply(8'h00, 8'hFF, N'(1) << k);
            check($sformatf("R5 lsr k=%0d", k), win_out, 8'hFF >> k, sel_err, 1'b0);
        end

        // R7 every adjacent pair of select lines
        for (int k = 0; k < N - 1; k++) begin
            apply(8'hFF, 8'hFF, N'(3) << k);
            check($sformatf("R7 pair k=%0d", k), win_out, 8'h00, sel_err, 1'b1);
        end

        // R8 a valid select after an invalid one clears the flag
        apply(8'hC3, 8'h00, 8'h00);
        check("R8 invalid first", win_out, 8'h00, sel_err, 1'b1);
        apply(8'hC3, 8'h00, 8'h20);
        check("R8 valid k=5", win_out, 8'h18, sel_err, 1'b0);

        // R9 output follows inputs between clock edges
        @(negedge clk);
        upper_in = 8'h00;
        lower_in = 8'h80;
        col_sel  = 8'h04;
        #0.5;
        check("R9 no edge A", win_out, 8'h20, sel_err, 1'b0);
        col_sel = 8'h08;
        #0.5;
        check("R9 no edge B", win_out, 8'h10, sel_err, 1'b0);
        lower_in = 8'h40;
        #0.5;
        check("R9 no edge C", win_out, 8'h08, sel_err, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule